// File: doc/BRIEF.md
# Lane Drive Adjustment Resolver

This block turns the per-lane drive adjustment requests that a display sink reports during link training into settings for both ends of the link. It takes two inputs. The first is a 16-bit adjust-request word that holds four bits per lane. The second is an 8-bit post-cursor request word that holds two bits per lane.

For each active lane, the block decodes the requested voltage swing and pre-emphasis. It clamps the pair jointly so that swing plus pre-emphasis never exceeds 3, and it raises max-reached flags where a ceiling was hit. The block produces three things:
- one configuration byte per lane, to be written back to the sink;
- the post-cursor configuration bytes, with two lanes packed per byte;
- the clamped levels alone, for the analog drive.

A request enters through a valid/ready handshake. The resolver takes one request at a time. `in_ready` is high only while it is idle, and a source that raises `in_valid` while `in_ready` is low must hold the request and its valid until it is accepted. After acceptance the block resolves one lane per clock. It then pulses `done` for one cycle. The results stay on the outputs until the next request is accepted, so the output side needs no back-pressure.

Top module: `ldr_resolver`

## Requirements
- R1: Lane i takes its request nibble from `adj_req[4i+3:4i]`, so bits 7:0 cover lanes 0 and 1 (even lane in the low nibble) and bits 15:8 cover lanes 2 and 3. Within a nibble, bits 1:0 are the requested swing and bits 3:2 the requested pre-emphasis.
- R2: A lane whose requested pre-emphasis is 3 gets pre-emphasis 3 with its pre-emphasis max flag set and swing 0 with no swing flag, which is configuration byte 0x38.
- R3: A lane whose requested pre-emphasis p is below 3 and whose requested swing is at least 3-p gets swing 3-p with the swing max flag set.
- R4: The lane configuration byte (`lane_cfg[8i+7:8i]`) is laid out as follows. Bits 1:0 hold the swing, bit 2 the swing max flag, bits 4:3 the pre-emphasis, bit 5 the pre-emphasis max flag, and bits 7:6 are zero. A lane whose request exceeds no ceiling keeps its requested levels, with both flags clear.
- R5: The post-cursor request for lane i is `pc_req[2i+1:2i]`. Its result nibble is placed at `pc_cfg[4i+3:4i]`. A request of 3 yields nibble 7 (level 3 plus max flag at nibble bit 2), and any lower request is passed through unchanged.
- R6: The effective lane count is n = min(`lane_cnt`, 4). Lanes i >= n get a zero configuration byte, a zero post-cursor nibble and zero levels.
- R7: A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` stays low from that edge until `done` has been seen. `done` is high in the cycle that follows the max(n,1)-th clock edge after the accepting edge.
- R8: `done` lasts exactly one cycle. After it, `in_ready` is high again, and all result outputs hold their values until the next request is accepted.
- R9: Each accepted request clears every earlier result, including post-cursor nibbles and lanes the new request leaves inactive.
- R10: `swing_lvl`, `preemph_lvl` and `pcur_lvl` carry the clamped 2-bit levels of lane i at bits 2i+1:2i, without flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Resolver idle, request can be taken |
| adj_req | input | 16 | Adjust-request nibbles, lane i at bits 4i+3:4i |
| pc_req | input | 8 | Post-cursor requests, lane i at bits 2i+1:2i |
| lane_cnt | input | 3 | Active lane count (1, 2 or 4 in use) |
| done | output | 1 | One-cycle pulse when the results are complete |
| lane_cfg | output | 32 | Per-lane configuration bytes |
| pc_cfg | output | 16 | Packed post-cursor configuration bytes |
| swing_lvl | output | 8 | Clamped swing levels |
| preemph_lvl | output | 8 | Clamped pre-emphasis levels |
| pcur_lvl | output | 8 | Clamped post-cursor levels |

## Verification
The sweep runs each lane count from 0 to 5 through 256 requests. Across those requests every lane sees every request nibble and every post-cursor code, so each boundary of the joint clamp gets hit:
- Pre-emphasis at 3 is checked because a design that skipped the forced swing would leave swing above 0 and break the sum limit.
- A swing exactly at the ceiling is checked because using "greater than" instead of "at or above" would leave its flag clear.
- A post-cursor request of 3 is checked because a missing flag would give nibble 3 instead of 7.

Lane counts of 3 and 5 catch a design that trusts the count unclamped or miscounts inactive lanes. A four-lane full-scale request followed by a one-lane zero request catches results left over from an earlier request. The latency and pulse checks catch a sequencer that is off by one lane or drops `done` late.

// File: rtl/ldr_pkg.sv
package ldr_pkg;
  localparam int LVL_W  = 2;
  localparam int NIB_W  = 4;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic [LVL_W-1:0] swing;
    logic             swing_max;
    logic [LVL_W-1:0] preemph;
    logic             preemph_max;
    logic [LVL_W-1:0] pcur;
    logic             pcur_max;
  } lane_res_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_t;
endpackage

// File: rtl/ldr_lane_select.sv
module ldr_lane_select #(
  parameter int MAX_LANES = 4,
  localparam int CNT_W = $clog2(MAX_LANES + 1)
) (
  input  logic [4*MAX_LANES-1:0] adj_q,
  input  logic [2*MAX_LANES-1:0] pc_q,
  input  logic [CNT_W-1:0]       idx,
  output logic [3:0]             nib,
  output logic [1:0]             pc2
);
  always_comb begin
    nib = '0;
    pc2 = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (idx == CNT_W'(i)) begin
        nib = adj_q[i*4 +: 4];
        pc2 = pc_q[i*2 +: 2];
      end
    end
  end
endmodule

// File: rtl/ldr_lane_clamp.sv
module ldr_lane_clamp
  import ldr_pkg::*;
(
  input  logic [3:0] nib,
  input  logic [1:0] pc2,
  output lane_res_t  res
);
  logic [1:0] req_sw;
  logic [1:0] req_pe;
  logic [1:0] sw_ceil;

  assign req_sw  = nib[1:0];
  assign req_pe  = nib[3:2];
  assign sw_ceil = 2'd3 - req_pe;

  always_comb begin
    res = '0;
    if (req_pe == 2'd3) begin
      res.preemph     = 2'd3;
      res.preemph_max = 1'b1;
      res.swing       = 2'd0;
      res.swing_max   = 1'b0;
    end else if (req_sw >= sw_ceil) begin
      res.preemph   = req_pe;
      res.swing     = sw_ceil;
      res.swing_max = 1'b1;
    end else begin
      res.preemph = req_pe;
      res.swing   = req_sw;
    end
    res.pcur     = pc2;
    res.pcur_max = (pc2 == 2'd3);
  end
endmodule

// File: rtl/ldr_seq.sv
module ldr_seq
  import ldr_pkg::*;
#(
  parameter int MAX_LANES = 4,
  localparam int CNT_W = $clog2(MAX_LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CNT_W-1:0] cnt_q,
  output logic             in_ready,
  output logic             accept,
  output logic             wr_en,
  output logic [CNT_W-1:0] idx,
  output logic             done
);
  seq_state_t state;
  logic       last;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign wr_en    = (state == ST_RUN) && (idx < cnt_q);
  assign last     = (cnt_q == '0) || (idx == cnt_q - CNT_W'(1));
  assign done     = (state == ST_FIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state <= ST_RUN;
          idx   <= '0;
        end
        ST_RUN: begin
          idx <= idx + CNT_W'(1);
          if (last) state <= ST_FIN;
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ldr_resolver.sv
module ldr_resolver
  import ldr_pkg::*;
#(
  parameter int MAX_LANES = 4,
  localparam int CNT_W = $clog2(MAX_LANES + 1),
  localparam int PCB   = (MAX_LANES + 1) / 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [4*MAX_LANES-1:0] adj_req,
  input  logic [2*MAX_LANES-1:0] pc_req,
  input  logic [CNT_W-1:0]       lane_cnt,
  output logic                   done,
  output logic [8*MAX_LANES-1:0] lane_cfg,
  output logic [8*PCB-1:0]       pc_cfg,
  output logic [2*MAX_LANES-1:0] swing_lvl,
  output logic [2*MAX_LANES-1:0] preemph_lvl,
  output logic [2*MAX_LANES-1:0] pcur_lvl
);
  logic [4*MAX_LANES-1:0] adj_q;
  logic [2*MAX_LANES-1:0] pc_q;
  logic [CNT_W-1:0]       cnt_q;
  logic [CNT_W-1:0]       cnt_eff;
  logic                   accept;
  logic                   wr_en;
  logic [CNT_W-1:0]       idx;
  logic [3:0]             nib;
  logic [1:0]             pc2;
  lane_res_t              res;
  logic [BYTE_W-1:0]      cfg_byte;
  logic [3:0]             pc_nib;

  assign cnt_eff = (lane_cnt > CNT_W'(MAX_LANES)) ? CNT_W'(MAX_LANES) : lane_cnt;

  ldr_seq #(.MAX_LANES(MAX_LANES)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cnt_q(cnt_q),
    .in_ready(in_ready), .accept(accept), .wr_en(wr_en), .idx(idx), .done(done)
  );

  ldr_lane_select #(.MAX_LANES(MAX_LANES)) u_sel (
    .adj_q(adj_q), .pc_q(pc_q), .idx(idx), .nib(nib), .pc2(pc2)
  );

  ldr_lane_clamp u_clamp (.nib(nib), .pc2(pc2), .res(res));

  assign cfg_byte = {2'b00, res.preemph_max, res.preemph, res.swing_max, res.swing};
  assign pc_nib   = {1'b0, res.pcur_max, res.pcur};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adj_q       <= '0;
      pc_q        <= '0;
      cnt_q       <= '0;
      lane_cfg    <= '0;
      pc_cfg      <= '0;
      swing_lvl   <= '0;
      preemph_lvl <= '0;
      pcur_lvl    <= '0;
    end else if (accept) begin
      adj_q       <= adj_req;
      pc_q        <= pc_req;
      cnt_q       <= cnt_eff;
      lane_cfg    <= '0;
      pc_cfg      <= '0;
      swing_lvl   <= '0;
      preemph_lvl <= '0;
      pcur_lvl    <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < MAX_LANES; i++) begin
        if (idx == CNT_W'(i)) begin
          lane_cfg[i*8 +: 8]    <= cfg_byte;
          pc_cfg[i*4 +: 4]      <= pc_cfg[i*4 +: 4] | pc_nib;
          swing_lvl[i*2 +: 2]   <= res.swing;
          preemph_lvl[i*2 +: 2] <= res.preemph;
          pcur_lvl[i*2 +: 2]    <= res.pcur;
        end
      end
    end
  end
endmodule

// File: rtl/ldr_checker.sv
module ldr_checker #(
  parameter int MAX_LANES = 4,
  localparam int CNT_W = $clog2(MAX_LANES + 1),
  localparam int PCB   = (MAX_LANES + 1) / 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   in_valid,
  input logic                   in_ready,
  input logic                   done,
  input logic [8*MAX_LANES-1:0] lane_cfg,
  input logic [8*PCB-1:0]       pc_cfg,
  input logic [2*MAX_LANES-1:0] swing_lvl,
  input logic [2*MAX_LANES-1:0] preemph_lvl,
  input logic [CNT_W-1:0]       cnt_q
);
  p_ready_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && in_ready));

  p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> ($stable(lane_cfg) && $stable(pc_cfg)));

  for (genvar i = 0; i < MAX_LANES; i++) begin : g_lane
    p_sum_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ({1'b0, swing_lvl[i*2 +: 2]} + {1'b0, preemph_lvl[i*2 +: 2]} <= 3'd3));

    p_pe_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (lane_cfg[i*8+5] == (preemph_lvl[i*2 +: 2] == 2'd3)));

    p_pc_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (pc_cfg[i*4+2] == (pc_cfg[i*4 +: 2] == 2'd3)));

    p_inactive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (cnt_q <= CNT_W'(i))) |-> (lane_cfg[i*8 +: 8] == 8'h00));
  end
endmodule

bind ldr_resolver ldr_checker #(.MAX_LANES(MAX_LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .lane_cfg(lane_cfg), .pc_cfg(pc_cfg),
  .swing_lvl(swing_lvl), .preemph_lvl(preemph_lvl), .cnt_q(cnt_q)
);

// File: tb/ldr_resolver_test.sv
`timescale 1ns/1ps
module ldr_resolver_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] adj_req = '0;
  logic [7:0]  pc_req = '0;
  logic [2:0]  lane_cnt = '0;
  logic        done;
  logic [31:0] lane_cfg;
  logic [15:0] pc_cfg;
  logic [7:0]  swing_lvl, preemph_lvl, pcur_lvl;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  ldr_resolver uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .adj_req(adj_req), .pc_req(pc_req), .lane_cnt(lane_cnt), .done(done),
    .lane_cfg(lane_cfg), .pc_cfg(pc_cfg), .swing_lvl(swing_lvl),
    .preemph_lvl(preemph_lvl), .pcur_lvl(pcur_lvl)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [3:0] n);
    int pe = n[3:2];
    int sw = n[1:0];
    if (pe == 3) return 8'h38;
    if (sw >= 3 - pe) return 8'((pe << 3) | 4 | (3 - pe));
    return 8'((pe << 3) | sw);
  endfunction

  function automatic string lane_tag(input logic [3:0] n, input bit active);
    if (!active) return "R6 inactive lane";
    if (n[3:2] == 2'd3) return "R2 pre-emphasis max";
    if (int'(n[1:0]) >= 3 - int'(n[3:2])) return "R3 swing ceiling";
    return "R4 pass-through";
  endfunction

  task automatic run_op(input int n, input logic [15:0] adj, input logic [7:0] pc);
    int eff = (n > 4) ? 4 : n;
    int lat = 0;
    bit busy_ok = 1;
    logic [15:0] exp_pc = '0;
    logic [7:0]  exp_sw = '0, exp_pe = '0, exp_pcl = '0;
    logic [31:0] cfg_hold;
    while (!in_ready) @(negedge clk);
    adj_req = adj; pc_req = pc; lane_cnt = 3'(n); in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; adj_req = '1; pc_req = '1; lane_cnt = 3'd1;
    while (!done && lat < 20) begin
      if (in_ready) busy_ok = 0;
      @(posedge clk); lat++;
      @(negedge clk);
    end
    check(busy_ok, "R7 in_ready low while busy", 0, 0);
    check(lat == ((eff > 1) ? eff : 1), "R7 done latency", lat, (eff > 1) ? eff : 1);
    for (int i = 0; i < 4; i++) begin
      logic [3:0] nb = adj[i*4 +: 4];
      bit act = (i < eff);
      logic [7:0] eb = act ? exp_byte(nb) : 8'h00;
      logic [1:0] pr = pc[i*2 +: 2];
      check(lane_cfg[i*8 +: 8] == eb, lane_tag(nb, act), lane_cfg[i*8 +: 8], eb);
      if (act) begin
        exp_pc[i*4 +: 4] = (pr == 2'd3) ? 4'h7 : {2'b00, pr};
        exp_sw[i*2 +: 2] = eb[1:0];
        exp_pe[i*2 +: 2] = eb[4:3];
        exp_pcl[i*2 +: 2] = pr;
      end
    end
    check(pc_cfg == exp_pc, "R5 post-cursor bytes", pc_cfg, exp_pc);
    check({swing_lvl, preemph_lvl, pcur_lvl} == {exp_sw, exp_pe, exp_pcl},
          "R10 level outputs", {swing_lvl, preemph_lvl, pcur_lvl}, {exp_sw, exp_pe, exp_pcl});
    cfg_hold = lane_cfg;
    @(posedge clk); @(negedge clk);
    check(!done && in_ready, "R8 done single pulse, ready back", {done, in_ready}, 1);
    @(posedge clk); @(negedge clk);
    check(lane_cfg == cfg_hold, "R8 outputs held while idle", lane_cfg, cfg_hold);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && !done, "reset ready/done", {in_ready, done}, 2);
    check(lane_cfg == 0 && pc_cfg == 0, "reset outputs", lane_cfg, 0);

    // R1: only lane 1 (high nibble of low byte) asks for swing 2
    run_op(4, 16'h0020, 8'h00);
    check(lane_cfg == 32'h0000_0200, "R1 nibble placement", lane_cfg, 32'h0000_0200);
    // R1: lane 2 low nibble of high byte, pre-emphasis 1 swing 1
    run_op(4, 16'h0500, 8'h00);
    check(lane_cfg == 32'h0009_0000, "R1 nibble placement lane 2", lane_cfg, 32'h0009_0000);

    // R9: full-scale request then a one-lane zero request
    run_op(4, 16'hFFFF, 8'hFF);
    run_op(1, 16'h0000, 8'h00);
    check(lane_cfg == 0 && pc_cfg == 0, "R9 earlier results cleared", lane_cfg | pc_cfg, 0);

    for (int n = 0; n <= 5; n++) begin
      for (int p = 0; p < 256; p++) begin
        logic [15:0] a;
        for (int k = 0; k < 4; k++)
          a[k*4 +: 4] = 4'(p + 5*k + (p >> 4) * 3 * k);
        run_op(n, a, 8'(p ^ (p >> 4)));
      end
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog R7 actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule